// File: doc/BRIEF.md
# Double-Buffered Bit-Plane Framebuffer Writer

This block sits between a pixel-drawing layer and the scan engine of a multiplexed RGB LED matrix that is driven as two half-panels at once. Each pixel write carries an (x, y) coordinate and a 24-bit colour. The block splits the colour into bit planes and stores them in byte-wide RAM. Each byte holds the same plane bit of two pixels, one from each half-panel, so the scan engine can fetch one byte per column per plane and drive both halves together.

Two RAM banks work as a ping-pong pair. The scan engine reads only the displayed bank. Pixel writes go only to the other bank, the drawing bank. A commit request is held until the scan engine signals a frame boundary. At that boundary the banks swap roles, and the bank that has just stopped being displayed is zero-filled so that it becomes a clean drawing bank. Each pixel write is a read-modify-write over all planes. It replaces only the 3-bit group of the target half-panel and keeps the other half's bits in the same byte.

Top module: `bitplane_fb`

## Requirements
- R1: Coordinates are mirrored before storage: xm = W-1-x and ym = H-1-y. Plane p of a pixel lives at byte address p*W + xm + (ym mod H/2)*W*B in a bank of W*H/2*B bytes.
- R2: A pixel with ym >= H/2 occupies byte bits [5:3]; any other pixel occupies bits [2:0]. Bits [7:6] of every stored byte read as 0.
- R3: `px_rgb` carries red in [23:16], green in [15:8] and blue in [7:0]. Within a pixel's 3-bit group, bit 0 is red, bit 1 is green and bit 2 is blue, all taken from colour bit p for plane p.
- R4: A write clears only its own 3-bit group before merging the new bits. The other half-panel's group in the same byte is preserved, and rewriting a pixel fully replaces its old colour.
- R5: Writes land only in the drawing bank. Data seen on the scan port does not change until a swap.
- R6: `disp_bank` toggles only in the cycle after a `frame_end` pulse that arrives while a commit is pending. A `frame_end` pulse with no pending commit has no effect.
- R7: After a swap, the previously displayed bank is zero-filled one byte per cycle, and `px_ready` stays low for exactly W*H/2*B cycles after the swap.
- R8: A write with x >= W or y >= H is accepted (it consumes the request) but changes nothing, and `px_ready` stays high the next cycle.
- R9: An accepted in-range write holds `px_ready` low for exactly B+1 cycles.
- R10: When `commit` and a write request arrive in the same ready cycle, the commit is taken and the write is discarded. A `commit` pulse while `px_ready` is low is ignored.
- R11: After reset, `disp_bank` is 0, `px_ready` is 1 and both banks read as all zero.
- R12: `scan_data` presents the displayed bank's byte at `scan_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel write request |
| px_x | input | $clog2(W)+1 | Pixel column |
| px_y | input | $clog2(H)+1 | Pixel row |
| px_rgb | input | 24 | Pixel colour, R/G/B bytes |
| px_ready | output | 1 | Block can take a write or commit this cycle |
| commit | input | 1 | Request to show the drawing bank |
| frame_end | input | 1 | Frame boundary pulse from the scan logic |
| scan_addr | input | $clog2(W*H/2*B) | Byte address in the displayed bank |
| scan_data | output | 8 | Byte from the displayed bank, one cycle latency |
| disp_bank | output | 1 | Index of the displayed bank |

## Verification
The bench writes two pixels, one from each half-panel, into the same byte and then rewrites one of them. A design that cleared the whole byte would lose the neighbour, and one that only ORed in the new colour would keep stale bits. It holds a commit pending across many cycles without a frame boundary to catch a swap that comes too early. It also checks that the clear finishes at the exact byte count, because a clear that stops one byte short would leave old pixels in the next drawing bank. A commit raised together with a write, and a commit raised during a busy write, show whether the design drops the right request. A design that got this wrong would shift a pixel into the wrong bank or swap banks unexpectedly.

// File: rtl/bitplane_fb_pkg.sv
package bitplane_fb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_PEND  = 2'd2,
    ST_CLEAR = 2'd3
  } fb_state_e;

  // Replace one 3-bit colour group of a stored byte, keep the other group.
  function automatic logic [7:0] merge_group(input logic [7:0] old_byte,
                                             input logic       upper,
                                             input logic [2:0] bgr);
    logic [7:0] mask;
    logic [7:0] ins;
    mask = upper ? 8'h38 : 8'h07;
    ins  = upper ? {2'b00, bgr, 3'b000} : {5'b00000, bgr};
    return ((old_byte & ~mask) | ins) & 8'h3F;
  endfunction

endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fb_map.sv
module fb_map #(
  parameter int W  = 16,
  parameter int H  = 8,
  parameter int B  = 8,
  parameter int XW = $clog2(W) + 1,
  parameter int YW = $clog2(H) + 1,
  parameter int AW = $clog2(W * H / 2 * B)
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic          in_range,
  output logic          upper,
  output logic [AW-1:0] base
);

  localparam int HALF = H / 2;

  always_comb begin
    int xm;
    int ym;
    int row;
    in_range = (int'(x) < W) && (int'(y) < H);
    xm       = W - 1 - int'(x);
    ym       = H - 1 - int'(y);
    upper    = in_range && (ym >= HALF);
    row      = (ym >= HALF) ? (ym - HALF) : ym;
    if (!in_range) begin
      xm  = 0;
      row = 0;
    end
    base = AW'(xm + row * W * B);
  end

endmodule

// File: rtl/fb_seq.sv
module fb_seq
  import bitplane_fb_pkg::*;
#(
  parameter int W     = 16,
  parameter int B     = 8,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = $clog2(B + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic          in_range,
  input  logic          upper,
  input  logic [AW-1:0] base,
  input  logic [23:0]   rgb,
  input  logic          commit,
  input  logic          frame_end,
  input  logic [7:0]    draw_q,
  output logic          ready,
  output logic [AW-1:0] eng_raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          disp
);

  fb_state_e     st;
  logic [PW-1:0] plane;
  logic [AW-1:0] base_q;
  logic [AW-1:0] prev_addr;
  logic [AW-1:0] clr_addr;
  logic          upper_q;
  logic [23:0]   rgb_q;

  assign ready     = (st == ST_IDLE);
  assign eng_raddr = base_q + AW'(int'(plane) * W);
  assign we        = ((st == ST_WRITE) && (plane != '0)) || (st == ST_CLEAR);
  assign waddr     = (st == ST_CLEAR) ? clr_addr : prev_addr;

  always_comb begin
    int pl;
    logic [2:0] bgr;
    pl  = (plane == '0) ? 0 : int'(plane) - 1;
    bgr = {rgb_q[pl], rgb_q[8 + pl], rgb_q[16 + pl]};
    if (st == ST_CLEAR) wdata = 8'h00;
    else                wdata = merge_group(draw_q, upper_q, bgr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      plane     <= '0;
      base_q    <= '0;
      prev_addr <= '0;
      clr_addr  <= '0;
      upper_q   <= 1'b0;
      rgb_q     <= '0;
      disp      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (commit) begin
            st <= ST_PEND;
          end else if (px_valid && in_range) begin
            st      <= ST_WRITE;
            plane   <= '0;
            base_q  <= base;
            upper_q <= upper;
            rgb_q   <= rgb;
          end
        end
        ST_WRITE: begin
          prev_addr <= eng_raddr;
          plane     <= plane + 1'b1;
          if (plane == PW'(B)) st <= ST_IDLE;
        end
        ST_PEND: begin
          if (frame_end) begin
            disp     <= ~disp;
            clr_addr <= '0;
            st       <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == AW'(DEPTH - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitplane_fb.sv
module bitplane_fb #(
  parameter int W     = 16,
  parameter int H     = 8,
  parameter int B     = 8,
  parameter int XW    = $clog2(W) + 1,
  parameter int YW    = $clog2(H) + 1,
  parameter int DEPTH = W * H / 2 * B,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic [XW-1:0] px_x,
  input  logic [YW-1:0] px_y,
  input  logic [23:0]   px_rgb,
  output logic          px_ready,
  input  logic          commit,
  input  logic          frame_end,
  input  logic [AW-1:0] scan_addr,
  output logic [7:0]    scan_data,
  output logic          disp_bank
);

  logic          in_range;
  logic          upper;
  logic [AW-1:0] base;
  logic [AW-1:0] eng_raddr;
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;
  logic [7:0]    draw_q;
  logic          disp;
  logic          disp_d;
  logic [7:0]    bank_q [2];

  fb_map #(.W(W), .H(H), .B(B), .XW(XW), .YW(YW), .AW(AW)) u_map (
    .x        (px_x),
    .y        (px_y),
    .in_range (in_range),
    .upper    (upper),
    .base     (base)
  );

  fb_seq #(.W(W), .B(B), .DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .px_valid  (px_valid),
    .in_range  (in_range),
    .upper     (upper),
    .base      (base),
    .rgb       (px_rgb),
    .commit    (commit),
    .frame_end (frame_end),
    .draw_q    (draw_q),
    .ready     (px_ready),
    .eng_raddr (eng_raddr),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .disp      (disp)
  );

  // Displayed bank's read port serves the scan side, the drawing bank's
  // read port serves the read-modify-write engine.
  for (genvar i = 0; i < 2; i++) begin : g_bank
    logic          shown;
    logic [AW-1:0] raddr;
    assign shown = (disp == 1'(i));
    assign raddr = shown ? scan_addr : eng_raddr;
    fb_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (we && !shown),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (bank_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) disp_d <= 1'b0;
    else     disp_d <= disp;
  end

  assign draw_q    = disp ? bank_q[0] : bank_q[1];
  assign scan_data = disp_d ? bank_q[1] : bank_q[0];
  assign disp_bank = disp;

endmodule

// File: rtl/bitplane_fb_chk.sv
module bitplane_fb_chk #(
  parameter int W  = 16,
  parameter int H  = 8,
  parameter int XW = $clog2(W) + 1,
  parameter int YW = $clog2(H) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          px_valid,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          px_ready,
  input logic          commit,
  input logic          frame_end,
  input logic [7:0]    scan_data,
  input logic          disp_bank
);

  logic in_rng;
  assign in_rng = (int'(px_x) < W) && (int'(px_y) < H);

  // R6
  swap_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_bank) |-> $past(frame_end));

  // R6
  idle_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && px_ready && !commit) |=> $stable(disp_bank));

  // R9
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (px_valid && px_ready && !commit && in_rng) |=> !px_ready);

  // R8
  range_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (px_valid && px_ready && !commit && !in_rng) |=> px_ready);

  // R10
  commit_take_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && px_ready) |=> !px_ready);

  // R7
  swap_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_bank) |-> !px_ready);

  // R2
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    scan_data[7:6] == 2'b00);

endmodule

bind bitplane_fb bitplane_fb_chk #(.W(W), .H(H), .XW(XW), .YW(YW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .px_valid  (px_valid),
  .px_x      (px_x),
  .px_y      (px_y),
  .px_ready  (px_ready),
  .commit    (commit),
  .frame_end (frame_end),
  .scan_data (scan_data),
  .disp_bank (disp_bank)
);

// File: tb/tb_bitplane_fb.sv
`timescale 1ns/1ps
module tb_bitplane_fb;

  localparam int W     = 16;
  localparam int H     = 8;
  localparam int B     = 8;
  localparam int XW    = $clog2(W) + 1;
  localparam int YW    = $clog2(H) + 1;
  localparam int DEPTH = W * H / 2 * B;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          px_valid = 1'b0;
  logic [XW-1:0] px_x = '0;
  logic [YW-1:0] px_y = '0;
  logic [23:0]   px_rgb = '0;
  logic          px_ready;
  logic          commit = 1'b0;
  logic          frame_end = 1'b0;
  logic [AW-1:0] scan_addr = '0;
  logic [7:0]    scan_data;
  logic          disp_bank;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [2][DEPTH];
  int mdisp = 0;

  always #4 clk = ~clk;

  bitplane_fb #(.W(W), .H(H), .B(B)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input int x, input int y, input logic [23:0] rgb);
    int xm, ym, sh, idx;
    logic [7:0] bits;
    if (x >= W || y >= H) return;
    xm = W - 1 - x;
    ym = H - 1 - y;
    sh = (ym >= H / 2) ? 3 : 0;
    for (int p = 0; p < B; p++) begin
      idx  = p * W + xm + (ym % (H / 2)) * W * B;
      bits = {5'b0, rgb[p], rgb[8 + p], rgb[16 + p]};
      mdl[1 - mdisp][idx] = (mdl[1 - mdisp][idx] & ~(8'h07 << sh)) | (bits << sh);
    end
  endtask

  task automatic do_write(input int x, input int y, input logic [23:0] rgb);
    @(negedge clk);
    while (!px_ready) @(negedge clk);
    px_valid = 1'b1;
    px_x = XW'(x);
    px_y = YW'(y);
    px_rgb = rgb;
    @(negedge clk);
    px_valid = 1'b0;
    model_write(x, y, rgb);
    while (!px_ready) @(negedge clk);
  endtask

  task automatic do_commit();
    @(negedge clk);
    while (!px_ready) @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    repeat (3) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    while (!px_ready) @(negedge clk);
    mdisp = 1 - mdisp;
    for (int i = 0; i < DEPTH; i++) mdl[1 - mdisp][i] = 8'h00;
  endtask

  task automatic read_scan(input int addr, output logic [7:0] val);
    @(negedge clk);
    scan_addr = AW'(addr);
    @(negedge clk);
    val = scan_data;
  endtask

  task automatic compare_bank(input string req);
    logic [7:0] v;
    int bad = 0;
    int first = -1;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < DEPTH; i++) begin
      read_scan(i, v);
      if (v !== mdl[mdisp][i]) begin
        bad++;
        if (first < 0) begin first = i; fa = v; fe = mdl[mdisp][i]; end
      end
    end
    chk(bad == 0, req, int'(fa), int'(fe));
    if (bad != 0) $display("  %0d bytes differ, first at %0d", bad, first);
  endtask

  // R11: reset state
  task automatic t_reset();
    logic [7:0] v;
    chk(disp_bank == 1'b0, "R11 disp_bank", int'(disp_bank), 0);
    chk(px_ready == 1'b1, "R11 px_ready", int'(px_ready), 1);
    read_scan(0, v);
    chk(v == 8'h00, "R11 scan byte", int'(v), 0);
    compare_bank("R11 bank zero");
  endtask

  // R9: busy length, R5: drawing bank hidden
  task automatic t_busy();
    int lows = 0;
    @(negedge clk);
    px_valid = 1'b1; px_x = 2; px_y = 3; px_rgb = 24'hA5_3C_0F;
    @(negedge clk);
    px_valid = 1'b0;
    model_write(2, 3, 24'hA5_3C_0F);
    while (!px_ready) begin lows++; @(negedge clk); end
    chk(lows == B + 1, "R9 busy cycles", lows, B + 1);
    compare_bank("R5 scan unchanged before swap");
  endtask

  // R6, R7: swap waits for frame_end, clear length
  task automatic t_swap();
    int lows = 0;
    bit held = 1'b1;
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (disp_bank != 1'b0 || px_ready) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R6 no swap without frame_end", int'(disp_bank), 0);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(disp_bank == 1'b1, "R6 swap after frame_end", int'(disp_bank), 1);
    while (!px_ready) begin lows++; @(negedge clk); end
    chk(lows == DEPTH, "R7 clear cycles", lows, DEPTH);
    mdisp = 1 - mdisp;
    for (int i = 0; i < DEPTH; i++) mdl[1 - mdisp][i] = 8'h00;
    compare_bank("R1 shown after swap");
  endtask

  // R1, R3, R12: hand-computed addresses
  task automatic t_map();
    logic [7:0] v;
    do_write(0, 0, 24'h01_00_00);
    do_write(15, 7, 24'h01_02_04);
    do_commit();
    read_scan(399, v);
    chk(v == 8'h08, "R1 mirrored upper address 399", int'(v), 8'h08);
    read_scan(0, v);
    chk(v == 8'h01, "R3 red plane0 at addr 0", int'(v), 1);
    read_scan(16, v);
    chk(v == 8'h02, "R3 green plane1 at addr 16", int'(v), 2);
    read_scan(32, v);
    chk(v == 8'h04, "R12 blue plane2 at addr 32", int'(v), 4);
  endtask

  // R2, R4: both halves in one byte, rewrite
  task automatic t_share();
    logic [7:0] v;
    do_write(0, 0, 24'hFF_FF_FF);
    do_write(0, 4, 24'hFF_FF_FF);
    do_write(3, 1, 24'h12_34_56);
    do_write(3, 5, 24'hFE_DC_BA);
    do_write(3, 1, 24'h81_42_24);
    do_commit();
    read_scan(399, v);
    chk(v == 8'h3F, "R2 both groups white", int'(v), 8'h3F);
    compare_bank("R4 neighbour kept and rewrite replaces");
  endtask

  // R8: out of range ignored
  task automatic t_range();
    @(negedge clk);
    px_valid = 1'b1; px_x = XW'(W); px_y = 0; px_rgb = 24'hFFFFFF;
    @(negedge clk);
    px_valid = 1'b0;
    chk(px_ready == 1'b1, "R8 ready after x out of range", int'(px_ready), 1);
    do_write(0, H, 24'hFFFFFF);
    do_commit();
    compare_bank("R8 bank untouched by out-of-range");
  endtask

  // R7: a commit with no writes shows a cleared bank
  task automatic t_clear();
    do_commit();
    compare_bank("R7 cleared bank shown");
  endtask

  // R6: frame_end alone
  task automatic t_idle_fe();
    logic d0;
    d0 = disp_bank;
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    @(negedge clk);
    chk(disp_bank == d0, "R6 frame_end without commit", int'(disp_bank), int'(d0));
  endtask

  // R10: commit wins over write, commit while busy ignored
  task automatic t_collide();
    logic d0;
    @(negedge clk);
    commit = 1'b1; px_valid = 1'b1; px_x = 5; px_y = 2; px_rgb = 24'hFFFFFF;
    @(negedge clk);
    commit = 1'b0; px_valid = 1'b0;
    repeat (2) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    while (!px_ready) @(negedge clk);
    mdisp = 1 - mdisp;
    for (int i = 0; i < DEPTH; i++) mdl[1 - mdisp][i] = 8'h00;
    compare_bank("R10 simultaneous write dropped");
    d0 = disp_bank;
    @(negedge clk);
    px_valid = 1'b1; px_x = 6; px_y = 6; px_rgb = 24'h0F0F0F;
    @(negedge clk);
    px_valid = 1'b0;
    model_write(6, 6, 24'h0F0F0F);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    while (!px_ready) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    @(negedge clk);
    chk(disp_bank == d0 && px_ready, "R10 busy commit ignored", int'(disp_bank), int'(d0));
    do_commit();
    compare_bank("R10 write kept after ignored commit");
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) mdl[b][i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_busy();
    t_swap();
    t_map();
    t_share();
    t_range();
    t_clear();
    t_idle_fe();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule